// File: doc/BRIEF.md
# Serial-to-parallel bit deserializer

This block turns a one-bit stream, sampled on a fast clock, into parallel words. Each word appears on a slower clock that is related to the fast one. The fast clock runs at exactly `WIDTH` times the slow rate. Every slow cycle therefore carries `WIDTH` serial bits. Those bits are packed into one word, and the first bit received lands in the least significant position.

The fast domain keeps a bit counter and a shift register. On the fast edge that takes in the last bit of a word, the finished word is copied into a holding register. The slow domain then passes that word through `LAT` output registers, so consumers never see a partially built word.

Word boundaries are set by reset release. The first fast edge after reset is bit 0 of a word, and that edge must coincide with a rising edge of the slow clock (or follow it by a fraction of a fast period). Consumers clocked a little after the slow clock see the nominal latency of `LAT` slow cycles. Consumers clocked in phase with the slow clock see one cycle more.

Top module: `serial_word_gather`

## Requirements
- R1: The first serial bit of a word appears at bit 0 of `wordOut`. Each later bit fills the next higher position, and the last bit lands at bit `WIDTH-1`.
- R2: `WIDTH` serial bits, taken on `WIDTH` consecutive rising edges of `fastClk`, make up one word. Consecutive words follow each other with no gap and no overlap.
- R3: While `rst` is high, `wordOut` is zero, and this takes effect without waiting for a clock. After reset, `wordOut` stays zero until the first complete word has passed through the latency pipeline.
- R4: Take a word whose bit 0 is sampled on the fast edge at slow rising edge k. That word is present on `wordOut` from shortly after slow rising edge k+`LAT`, until slow rising edge k+`LAT`+1.
- R5: A register clocked on the same rising edge of `slowClk` captures that word at slow edge k+`LAT`+1. The observed latency is then `LAT`+1 cycles.
- R6: The same words, with the same slow-domain latency, are produced when the fast clock is delayed by a quarter of its period relative to the slow clock.
- R7: `wordOut` changes only at rising edges of `slowClk` and holds its value through the whole slow cycle. The holding register changes only on the fast edge that completes a word.
- R8: The first rising edge of `fastClk` after `rst` falls samples bit 0 of a word. The completion strobe pulses once every `WIDTH` fast cycles. At every rising edge of `slowClk`, the bit counter points at bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fastClk | input | 1 | Bit-rate clock, `WIDTH` times the slow rate |
| slowClk | input | 1 | Word-rate clock, edge-related to `fastClk` |
| rst | input | 1 | Asynchronous active-high reset for both domains |
| serialIn | input | 1 | Serial data bit, sampled on rising `fastClk` |
| wordOut | output | WIDTH | Parallel word, registered on `slowClk` |

## Verification
Suppose the bit counter slips by one position. Every later word then shows up rotated at the output, and the mismatch is visible `LAT`+1 slow cycles after the slip. If the holding register is loaded on the wrong fast edge, the word is sampled while it is still being built. A mix of adjacent words then appears at the output in the next slow cycle. The same stream is sent to a second copy whose fast clock is shifted by a quarter period. Both copies must produce identical words at identical slow edges, which separates a phase-sensitive hand-off from a plain data error.

// File: rtl/gather_pkg.sv
package gather_pkg;

  // Strobes from the fast-domain counter to the datapath
  typedef struct packed {
    logic firstBit;  // current fast edge samples bit 0 of a word
    logic wordDone;  // current fast edge samples the last bit of a word
  } gather_strobe_t;

endpackage

// File: rtl/gather_ctrl.sv
module gather_ctrl
  import gather_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic           fastClk,
  input  logic           rst,
  output gather_strobe_t strb
);

  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST_SLOT = CW'(WIDTH - 1);

  logic [CW-1:0] bitSlot;

  always_ff @(posedge fastClk or posedge rst) begin
    if (rst) begin
      bitSlot <= '0;
    end else if (bitSlot == LAST_SLOT) begin
      bitSlot <= '0;
    end else begin
      bitSlot <= bitSlot + 1'b1;
    end
  end

  always_comb begin
    strb.firstBit = (bitSlot == '0);
    strb.wordDone = (bitSlot == LAST_SLOT);
  end

endmodule

// File: rtl/gather_datapath.sv
module gather_datapath
  import gather_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int LAT   = 1
) (
  input  logic             fastClk,
  input  logic             slowClk,
  input  logic             rst,
  input  logic             serialIn,
  input  gather_strobe_t   strb,
  output logic [WIDTH-1:0] holdWord,
  output logic [WIDTH-1:0] wordOut
);

  logic [WIDTH-1:0] shiftWord;
  logic [WIDTH-1:0] nextWord;
  logic [WIDTH-1:0] stageWord [LAT];

  // New bits enter at the top and move down, so the first bit ends at position 0
  always_comb begin
    if (strb.firstBit) begin
      nextWord = {serialIn, {(WIDTH-1){1'b0}}};
    end else begin
      nextWord = {serialIn, shiftWord[WIDTH-1:1]};
    end
  end

  always_ff @(posedge fastClk or posedge rst) begin
    if (rst) begin
      shiftWord <= '0;
      holdWord  <= '0;
    end else begin
      shiftWord <= nextWord;
      if (strb.wordDone) begin
        holdWord <= nextWord;
      end
    end
  end

  // Slow-domain latency pipeline
  always_ff @(posedge slowClk or posedge rst) begin
    if (rst) begin
      for (int s = 0; s < LAT; s++) begin
        stageWord[s] <= '0;
      end
    end else begin
      stageWord[0] <= holdWord;
      for (int s = 1; s < LAT; s++) begin
        stageWord[s] <= stageWord[s-1];
      end
    end
  end

  assign wordOut = stageWord[LAT-1];

endmodule

// File: rtl/serial_word_gather.sv
module serial_word_gather
  import gather_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int LAT   = 1
) (
  input  logic             fastClk,
  input  logic             slowClk,
  input  logic             rst,
  input  logic             serialIn,
  output logic [WIDTH-1:0] wordOut
);

  gather_strobe_t   strb;
  logic [WIDTH-1:0] holdWord;

  gather_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .fastClk (fastClk),
    .rst     (rst),
    .strb    (strb)
  );

  gather_datapath #(.WIDTH(WIDTH), .LAT(LAT)) u_dp (
    .fastClk  (fastClk),
    .slowClk  (slowClk),
    .rst      (rst),
    .serialIn (serialIn),
    .strb     (strb),
    .holdWord (holdWord),
    .wordOut  (wordOut)
  );

endmodule

// File: rtl/gather_chk.sv
module gather_chk
  import gather_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int LAT   = 1
) (
  input logic             fastClk,
  input logic             slowClk,
  input logic             rst,
  input gather_strobe_t   strb,
  input logic [WIDTH-1:0] holdWord,
  input logic [WIDTH-1:0] wordOut
);

  // R3
  reset_zero_chk: assert property (@(posedge slowClk) rst |-> (wordOut == '0));

  // R8
  done_single_pulse_chk: assert property (@(posedge fastClk) disable iff (rst)
    strb.wordDone |=> !strb.wordDone);

  // R7
  hold_only_on_done_chk: assert property (@(posedge fastClk) disable iff (rst)
    !strb.wordDone |=> $stable(holdWord));

  // R8
  slow_edge_boundary_chk: assert property (@(posedge slowClk) disable iff (rst)
    strb.firstBit);

endmodule

bind serial_word_gather gather_chk #(.WIDTH(WIDTH), .LAT(LAT)) u_gather_chk (
  .fastClk  (fastClk),
  .slowClk  (slowClk),
  .rst      (rst),
  .strb     (strb),
  .holdWord (holdWord),
  .wordOut  (wordOut)
);

// File: tb/test_serial_word_gather.sv
module test_serial_word_gather;

  localparam int W   = 8;
  localparam int LTB = 2;
  localparam int NV  = 12;
  localparam logic [W-1:0] VEC [NV] = '{
    8'hCC, 8'hCC, 8'h33, 8'h33, 8'hAA, 8'h01,
    8'h80, 8'hFF, 8'h5A, 8'h0F, 8'hE1, 8'h00
  };

  logic fastClk = 1'b0;
  logic fastQ   = 1'b0;
  logic slowClk = 1'b0;
  logic rst     = 1'b1;
  logic din     = 1'b0;
  logic dinQ    = 1'b0;
  logic [W-1:0] wordOut, wordQ, alignedCap;

  int checks = 0;
  int errors = 0;

  // 250 MHz bit clock, quarter-shifted copy, word clock aligned to the bit clock
  initial forever #2 fastClk = ~fastClk;
  initial begin #3; forever begin fastQ = 1'b1; #2; fastQ = 1'b0; #2; end end
  initial begin #2; forever begin slowClk = 1'b1; #(2*W); slowClk = 1'b0; #(2*W); end end

  serial_word_gather #(.WIDTH(W), .LAT(LTB)) i_serial_word_gather (
    .fastClk(fastClk), .slowClk(slowClk), .rst(rst), .serialIn(din), .wordOut(wordOut)
  );

  serial_word_gather #(.WIDTH(W), .LAT(LTB)) i_serial_word_gather_q (
    .fastClk(fastQ), .slowClk(slowClk), .rst(rst), .serialIn(dinQ), .wordOut(wordQ)
  );

  // Consumer clocked in phase with the word clock
  always_ff @(posedge slowClk) alignedCap <= wordOut;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sendMain(input logic [W-1:0] w);
    for (int i = 0; i < W; i++) begin
      din = w[i];
      @(posedge fastClk);
      #2;
    end
  endtask

  task automatic sendQ(input logic [W-1:0] w);
    for (int i = 0; i < W; i++) begin
      dinQ = w[i];
      @(posedge fastQ);
      #2;
    end
  endtask

  task automatic sendBoth(input logic [W-1:0] w);
    fork
      sendMain(w);
      sendQ(w);
    join
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #20;
    chk("R3 reset main", wordOut, '0);
    chk("R3 reset shifted", wordQ, '0);
    #45;
    rst = 1'b0;  // one ns before the slow edge at 66
    fork
      begin
        for (int k = 0; k < NV; k++) sendBoth(VEC[k]);
      end
      begin
        logic [W-1:0] prevExp;
        prevExp = '0;
        @(posedge slowClk);
        repeat (LTB) begin
          #1;
          chk("R3 empty pipeline", wordOut, '0);
          @(posedge slowClk);
        end
        for (int k = 0; k < NV; k++) begin
          #1;
          chk("R1 R2 R4 word", wordOut, VEC[k]);
          chk("R6 shifted clock word", wordQ, VEC[k]);
          chk("R5 aligned consumer", alignedCap, prevExp);
          #(2*W);
          chk("R7 mid-cycle hold", wordOut, VEC[k]);
          prevExp = VEC[k];
          @(posedge slowClk);
        end
      end
    join

    // Reset in mid-run clears the output at once
    @(posedge slowClk);
    #5;
    rst = 1'b1;
    #1;
    chk("R3 async reset main", wordOut, '0);
    chk("R3 async reset shifted", wordQ, '0);
    @(posedge slowClk);
    #(4*W - 1);
    rst = 1'b0;
    fork
      sendBoth(8'h96);
      begin
        @(posedge slowClk);
        repeat (LTB) @(posedge slowClk);
        #1;
        chk("R8 realigned word main", wordOut, 8'h96);
        chk("R8 realigned word shifted", wordQ, 8'h96);
      end
    join

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule